// File: doc/BRIEF.md
# Two-Group Priority Interrupt Controller

This block gathers up to fifteen interrupt sources, numbered 1 to 15, and presents one processor with a 4-bit interrupt level. Each source sends a single-cycle request pulse. The controller latches the pulse into a shared pending vector, or into every processor's force vector when that source is marked for broadcast. Processor 0's mask selects which sources may interrupt. A group-select register places each source in either a high or a low priority group. The level driven out is the highest-numbered active source of the high group. When the high group has no active source, the level comes from the low group instead.

Software reaches the state through a 32-bit word bus. The bus has a one-cycle write strobe and a read strobe, and read data returns on the following cycle. The bus side is plain control with no valid/ready handshake: every access completes in fixed time and there is no back-pressure. The processor acknowledges an interrupt by pulsing `ack_valid` with the serviced number. This clears that source in the pending vector and in processor 0's force vector. Mask and force vectors are kept per processor for up to `NCPU` processors. Only processor 0's vectors drive the output.

Top module: `irq_prio_ctrl`

## Requirements
- R1: A pulse on `src_pulse[k]` (k from 1 to 15) whose broadcast bit is 0 sets bit k of the pending vector (read at offset 0x04) at the next clock edge.
- R2: Bit 0 is never stored. Writes to the group-select, force, clear, broadcast and mask registers discard data bit 0, and a pulse on `src_pulse[0]` is ignored.
- R3: The output level is 0 whenever no bit of (pending OR force0) AND mask0 is set. Mask0 is at offset 0x40 and force0 is at offset 0x80.
- R4: Group-select bits (offset 0x00) set to 1 form the high group. When any active bit lies in the high group, `irq_level` is the highest-numbered active high-group bit, even if a higher-numbered low-group bit is active. Otherwise `irq_level` is the highest-numbered active low-group bit.
- R5: Writing to offset 0x0C clears the written bits in both the pending vector and processor 0's force vector.
- R6: A write to the force vector of processor n (offset 0x80+4n) computes (old OR data[15:1]) AND NOT data[31:17]. A write to offset 0x08 replaces processor 0's force vector with data[15:1]. Offset 0x08 reads back processor 0's force vector.
- R7: A pulse on a source whose broadcast bit (offset 0x14) is 1 sets that bit in the force vector of every processor and leaves pending unchanged.
- R8: An acknowledge with number k clears bit k of the pending vector and of processor 0's force vector only.
- R9: If a request for bit k arrives in the same cycle as an acknowledge or a clear write for bit k, the bit stays set.
- R10: Writes to pending (0x04) and status (0x10) have no effect. Clear (0x0C), status, unmapped offsets and offsets with address bits 1:0 not zero read 0. Writes to unmapped or misaligned offsets change nothing.
- R11: Extended registers (offset 0xC0+4n) store and return only data bits 3:0.
- R12: `irq_level` is registered. It reflects a state change one clock edge after the edge that made the change.
- R13: `bus_rdata` carries the addressed value in the cycle after a cycle with `bus_rd` high, and is 0 after a cycle with `bus_rd` low.
- R14: Reset clears every register and the output level to zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| src_pulse | input | 16 | One-cycle request per source, bit 0 unused |
| bus_addr | input | 8 | Byte offset of the word access |
| bus_wr | input | 1 | Write strobe |
| bus_wdata | input | 32 | Write data |
| bus_rd | input | 1 | Read strobe |
| bus_rdata | output | 32 | Read data, one cycle after `bus_rd` |
| ack_valid | input | 1 | Acknowledge strobe |
| ack_num | input | 4 | Interrupt number being acknowledged |
| irq_level | output | 4 | Interrupt level presented to the processor, 0 for none |

## Verification
The hardest situation to reach is a collision: a new request lands on a bit in the very cycle that an acknowledge or a clear write removes it. From the ports this needs `src_pulse` and the removing strobe driven on the same edge. The stimulus sets up both in one low clock phase, then reads pending back.

The other hard case is a broadcast source. It has to be traced into force vectors of processors that never drive the output. The only way to see those vectors is to read them back over the bus, after an acknowledge that must touch processor 0 alone.

// File: rtl/irq_prio_pkg.sv
package irq_prio_pkg;

  typedef enum logic [3:0] {
    RG_NONE,
    RG_GROUP,
    RG_PEND,
    RG_FALIAS,
    RG_CLEAR,
    RG_STAT,
    RG_BCAST,
    RG_MASK,
    RG_FORCE,
    RG_EXT
  } region_e;

  typedef struct packed {
    region_e    rg;
    logic [3:0] idx;
  } dec_t;

  // word index inside the global window (address bits 5:2); these
  // positions are software-visible and fixed
  localparam logic [3:0] W_GROUP  = 4'd0;
  localparam logic [3:0] W_PEND   = 4'd1;
  localparam logic [3:0] W_FALIAS = 4'd2;
  localparam logic [3:0] W_CLEAR  = 4'd3;
  localparam logic [3:0] W_STAT   = 4'd4;
  localparam logic [3:0] W_BCAST  = 4'd5;

  // bank select on address bits 7:6
  localparam logic [1:0] B_GLOBAL = 2'd0;
  localparam logic [1:0] B_MASK   = 2'd1;
  localparam logic [1:0] B_FORCE  = 2'd2;
  localparam logic [1:0] B_EXT    = 2'd3;

endpackage

// File: rtl/irq_bus_decode.sv
module irq_bus_decode
  import irq_prio_pkg::*;
#(
  parameter int NCPU = 16
) (
  input  logic [7:0] addr,
  output dec_t       dec
);

  logic [3:0] word;
  assign word = addr[5:2];

  always_comb begin
    dec.rg  = RG_NONE;
    dec.idx = word;
    if (addr[1:0] == 2'b00) begin
      unique case (addr[7:6])
        B_GLOBAL: begin
          case (word)
            W_GROUP:  dec.rg = RG_GROUP;
            W_PEND:   dec.rg = RG_PEND;
            W_FALIAS: dec.rg = RG_FALIAS;
            W_CLEAR:  dec.rg = RG_CLEAR;
            W_STAT:   dec.rg = RG_STAT;
            W_BCAST:  dec.rg = RG_BCAST;
            default:  dec.rg = RG_NONE;
          endcase
        end
        B_MASK:  dec.rg = (int'(word) < NCPU) ? RG_MASK  : RG_NONE;
        B_FORCE: dec.rg = (int'(word) < NCPU) ? RG_FORCE : RG_NONE;
        B_EXT:   dec.rg = (int'(word) < NCPU) ? RG_EXT   : RG_NONE;
        default: dec.rg = RG_NONE;
      endcase
    end
  end

endmodule

// File: rtl/irq_state_regs.sv
module irq_state_regs
  import irq_prio_pkg::*;
#(
  parameter int NSRC = 16,
  parameter int NCPU = 16
) (
  input  logic                       clk,
  input  logic                       rst_n,
  input  dec_t                       dec,
  input  logic                       bus_wr,
  input  logic [31:0]                bus_wdata,
  input  logic [NSRC-1:0]            src_pulse,
  input  logic                       ack_valid,
  input  logic [3:0]                 ack_num,
  output logic [NSRC-1:0]            grp_o,
  output logic [NSRC-1:0]            pend_o,
  output logic [NSRC-1:0]            bcast_o,
  output logic [NCPU-1:0][NSRC-1:0]  mask_o,
  output logic [NCPU-1:0][NSRC-1:0]  frc_o,
  output logic [NCPU-1:0][3:0]       ext_o
);

  localparam logic [NSRC-1:0] VMASK = {{(NSRC-1){1'b1}}, 1'b0};

  logic [NSRC-1:0] wlow, whigh, ack_bits, clr_bits, req, req_pend, req_bc;
  logic [NSRC-1:0] grp_q, pend_q, bc_q;
  logic            alias_wr;

  assign wlow     = bus_wdata[NSRC-1:0] & VMASK;
  assign whigh    = bus_wdata[16 +: NSRC] & VMASK;
  assign ack_bits = ack_valid ? (NSRC'(1) << ack_num) : '0;
  assign clr_bits = ack_bits | ((bus_wr && dec.rg == RG_CLEAR) ? wlow : '0);
  assign req      = src_pulse & VMASK;
  assign req_pend = req & ~bc_q;
  assign req_bc   = req & bc_q;
  assign alias_wr = bus_wr && dec.rg == RG_FALIAS;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      grp_q  <= '0;
      pend_q <= '0;
      bc_q   <= '0;
    end else begin
      if (bus_wr && dec.rg == RG_GROUP) grp_q <= wlow;
      if (bus_wr && dec.rg == RG_BCAST) bc_q  <= wlow;
      // removal first, new requests last so a same-cycle request survives
      pend_q <= (pend_q & ~clr_bits) | req_pend;
    end
  end

  for (genvar c = 0; c < NCPU; c++) begin : g_cpu
    localparam bit IS_BOOT = (c == 0);
    logic [NSRC-1:0] frc_r, frc_n, msk_r;
    logic [3:0]      ext_r;
    logic            hit;

    assign hit = dec.idx == 4'(c);

    always_comb begin
      frc_n = frc_r;
      if (bus_wr && dec.rg == RG_FORCE && hit) frc_n = (frc_n | wlow) & ~whigh;
      if (IS_BOOT) begin
        if (alias_wr) frc_n = wlow;
        frc_n = frc_n & ~clr_bits;
      end
      frc_n = frc_n | req_bc;
    end

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        frc_r <= '0;
        msk_r <= '0;
        ext_r <= '0;
      end else begin
        frc_r <= frc_n;
        if (bus_wr && dec.rg == RG_MASK && hit) msk_r <= wlow;
        if (bus_wr && dec.rg == RG_EXT && hit)  ext_r <= bus_wdata[3:0];
      end
    end

    assign frc_o[c]  = frc_r;
    assign mask_o[c] = msk_r;
    assign ext_o[c]  = ext_r;
  end

  assign grp_o   = grp_q;
  assign pend_o  = pend_q;
  assign bcast_o = bc_q;

endmodule

// File: rtl/irq_level_out.sv
module irq_level_out #(
  parameter int NSRC = 16,
  localparam int LW  = $clog2(NSRC)
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic [NSRC-1:0] pend,
  input  logic [NSRC-1:0] frc0,
  input  logic [NSRC-1:0] mask0,
  input  logic [NSRC-1:0] grp,
  output logic [LW-1:0]   level
);

  logic [NSRC-1:0] active, hi, lo, sel;
  logic [LW-1:0]   enc, level_q;

  assign active = (pend | frc0) & mask0;
  assign hi     = active & grp;
  assign lo     = active & ~grp;
  assign sel    = (|hi) ? hi : lo;

  // highest set index wins; bit 0 is never set so 0 means idle
  always_comb begin
    enc = '0;
    for (int i = 1; i < NSRC; i++) begin
      if (sel[i]) enc = LW'(i);
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) level_q <= '0;
    else        level_q <= enc;
  end

  assign level = level_q;

endmodule

// File: rtl/irq_read_mux.sv
module irq_read_mux
  import irq_prio_pkg::*;
#(
  parameter int NSRC = 16,
  parameter int NCPU = 16
) (
  input  logic                      clk,
  input  logic                      rst_n,
  input  logic                      bus_rd,
  input  dec_t                      dec,
  input  logic [NSRC-1:0]           grp,
  input  logic [NSRC-1:0]           pend,
  input  logic [NSRC-1:0]           bcast,
  input  logic [NCPU-1:0][NSRC-1:0] mask,
  input  logic [NCPU-1:0][NSRC-1:0] frc,
  input  logic [NCPU-1:0][3:0]      ext,
  output logic [31:0]               rdata
);

  logic [31:0] val, rdata_q;

  always_comb begin
    case (dec.rg)
      RG_GROUP:  val = 32'(grp);
      RG_PEND:   val = 32'(pend);
      RG_FALIAS: val = 32'(frc[0]);
      RG_BCAST:  val = 32'(bcast);
      RG_MASK:   val = 32'(mask[dec.idx]);
      RG_FORCE:  val = 32'(frc[dec.idx]);
      RG_EXT:    val = 32'(ext[dec.idx]);
      default:   val = '0;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rdata_q <= '0;
    else        rdata_q <= bus_rd ? val : '0;
  end

  assign rdata = rdata_q;

endmodule

// File: rtl/irq_prio_ctrl.sv
module irq_prio_ctrl
  import irq_prio_pkg::*;
#(
  parameter int NSRC = 16,
  parameter int NCPU = 16
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic [NSRC-1:0]          src_pulse,
  input  logic [7:0]               bus_addr,
  input  logic                     bus_wr,
  input  logic [31:0]              bus_wdata,
  input  logic                     bus_rd,
  output logic [31:0]              bus_rdata,
  input  logic                     ack_valid,
  input  logic [3:0]               ack_num,
  output logic [$clog2(NSRC)-1:0]  irq_level
);

  dec_t                      dec;
  logic [NSRC-1:0]           grp_w, pend_w, bcast_w;
  logic [NCPU-1:0][NSRC-1:0] mask_w, frc_w;
  logic [NCPU-1:0][3:0]      ext_w;

  irq_bus_decode #(.NCPU(NCPU)) u_dec (
    .addr (bus_addr),
    .dec  (dec)
  );

  irq_state_regs #(.NSRC(NSRC), .NCPU(NCPU)) u_regs (
    .clk       (clk),
    .rst_n     (rst_n),
    .dec       (dec),
    .bus_wr    (bus_wr),
    .bus_wdata (bus_wdata),
    .src_pulse (src_pulse),
    .ack_valid (ack_valid),
    .ack_num   (ack_num),
    .grp_o     (grp_w),
    .pend_o    (pend_w),
    .bcast_o   (bcast_w),
    .mask_o    (mask_w),
    .frc_o     (frc_w),
    .ext_o     (ext_w)
  );

  irq_level_out #(.NSRC(NSRC)) u_lvl (
    .clk   (clk),
    .rst_n (rst_n),
    .pend  (pend_w),
    .frc0  (frc_w[0]),
    .mask0 (mask_w[0]),
    .grp   (grp_w),
    .level (irq_level)
  );

  irq_read_mux #(.NSRC(NSRC), .NCPU(NCPU)) u_rd (
    .clk    (clk),
    .rst_n  (rst_n),
    .bus_rd (bus_rd),
    .dec    (dec),
    .grp    (grp_w),
    .pend   (pend_w),
    .bcast  (bcast_w),
    .mask   (mask_w),
    .frc    (frc_w),
    .ext    (ext_w),
    .rdata  (bus_rdata)
  );

endmodule

// File: rtl/irq_prio_ctrl_chk.sv
module irq_prio_ctrl_chk #(
  parameter int NSRC = 16
) (
  input logic                    clk,
  input logic                    rst_n,
  input logic [NSRC-1:0]         src_pulse,
  input logic [7:0]              bus_addr,
  input logic                    bus_wr,
  input logic                    bus_rd,
  input logic [31:0]             bus_rdata,
  input logic                    ack_valid,
  input logic [$clog2(NSRC)-1:0] irq_level,
  input logic [NSRC-1:0]         pend,
  input logic [NSRC-1:0]         frc0,
  input logic [NSRC-1:0]         mask0,
  input logic [NSRC-1:0]         bcast
);

  localparam logic [NSRC-1:0] VM = {{(NSRC-1){1'b1}}, 1'b0};

  p_bit0_empty_r2: assert property (@(posedge clk) disable iff (!rst_n)
    !pend[0] && !frc0[0] && !mask0[0]);

  // also covers R9: a request is never lost to a same-cycle removal
  p_req_latch_r1: assert property (@(posedge clk) disable iff (!rst_n)
    |(src_pulse & ~bcast & VM) |=>
      ((pend & $past(src_pulse & ~bcast & VM)) == $past(src_pulse & ~bcast & VM)));

  p_bcast_force_r7: assert property (@(posedge clk) disable iff (!rst_n)
    |(src_pulse & bcast & VM) |=>
      ((frc0 & $past(src_pulse & bcast & VM)) == $past(src_pulse & bcast & VM)));

  p_nomask_quiet_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (mask0 == '0) |=> (irq_level == '0));

  p_rdata_idle_r13: assert property (@(posedge clk) disable iff (!rst_n)
    !bus_rd |=> (bus_rdata == '0));

  p_pend_ro_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_wr && bus_addr == 8'h04 && (src_pulse & ~bcast & VM) == '0 && !ack_valid)
      |=> (pend == $past(pend)));

endmodule

bind irq_prio_ctrl irq_prio_ctrl_chk #(.NSRC(NSRC)) u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .src_pulse (src_pulse),
  .bus_addr  (bus_addr),
  .bus_wr    (bus_wr),
  .bus_rd    (bus_rd),
  .bus_rdata (bus_rdata),
  .ack_valid (ack_valid),
  .irq_level (irq_level),
  .pend      (pend_w),
  .frc0      (frc_w[0]),
  .mask0     (mask_w[0]),
  .bcast     (bcast_w)
);

// File: tb/irq_prio_ctrl_test.sv
module irq_prio_ctrl_test;

  localparam int CLK_PERIOD = 10;

  typedef struct {
    bit          is_lvl;
    logic [31:0] exp;
    string       tag;
  } exp_t;

  logic        clk = 0;
  logic        rst_n = 0;
  logic [15:0] src_pulse = '0;
  logic [7:0]  bus_addr = '0;
  logic        bus_wr = 0;
  logic [31:0] bus_wdata = '0;
  logic        bus_rd = 0;
  logic [31:0] bus_rdata;
  logic        ack_valid = 0;
  logic [3:0]  ack_num = '0;
  logic [3:0]  irq_level;

  int   n_chk = 0;
  int   n_fail = 0;
  bit   done = 0;
  exp_t exp_q[$];

  always #(CLK_PERIOD/2) clk = ~clk;

  irq_prio_ctrl uut (
    .clk(clk), .rst_n(rst_n), .src_pulse(src_pulse), .bus_addr(bus_addr),
    .bus_wr(bus_wr), .bus_wdata(bus_wdata), .bus_rd(bus_rd),
    .bus_rdata(bus_rdata), .ack_valid(ack_valid), .ack_num(ack_num),
    .irq_level(irq_level)
  );

  // monitor: compares each expected item one time unit after it is queued
  initial begin
    forever begin
      exp_t it;
      logic [31:0] act;
      wait (exp_q.size() != 0);
      it = exp_q.pop_front();
      #1;
      act = it.is_lvl ? 32'(irq_level) : bus_rdata;
      n_chk++;
      if (act !== it.exp) begin
        n_fail++;
        $display("FAIL %s: actual 0x%0h expected 0x%0h", it.tag, act, it.exp);
      end
    end
  end

  task automatic push(bit lvl, logic [31:0] e, string tag);
    exp_t it;
    it.is_lvl = lvl; it.exp = e; it.tag = tag;
    exp_q.push_back(it);
  endtask

  task automatic wr_reg(logic [7:0] a, logic [31:0] d);
    @(negedge clk); bus_addr = a; bus_wdata = d; bus_wr = 1;
    @(negedge clk); bus_wr = 0;
  endtask

  task automatic rd_chk(logic [7:0] a, logic [31:0] e, string tag);
    @(negedge clk); bus_addr = a; bus_rd = 1;
    @(negedge clk); bus_rd = 0;
    push(0, e, tag);
  endtask

  task automatic pulse(logic [15:0] v);
    @(negedge clk); src_pulse = v;
    @(negedge clk); src_pulse = '0;
  endtask

  task automatic ack(logic [3:0] k);
    @(negedge clk); ack_valid = 1; ack_num = k;
    @(negedge clk); ack_valid = 0;
  endtask

  task automatic lvl_chk(logic [3:0] e, string tag);
    @(negedge clk); push(1, 32'(e), tag);
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      n_chk++; n_fail++;
      $display("FAIL watchdog: actual hung expected finished");
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1;
    push(1, 0, "R14 level after reset");
    rd_chk(8'h04, 0, "R14 pending after reset");

    // R10 read-only and zero-reading locations
    rd_chk(8'h0C, 0, "R10 clear reads zero");
    rd_chk(8'h10, 0, "R10 status reads zero");
    rd_chk(8'h20, 0, "R10 unmapped reads zero");
    wr_reg(8'h04, 32'hFFFF);
    rd_chk(8'h04, 0, "R10 pending write ignored");
    wr_reg(8'h42, 32'hFFFF);
    rd_chk(8'h40, 0, "R10 misaligned write ignored");
    wr_reg(8'h10, 32'hFFFF);
    rd_chk(8'h00, 0, "R10 status write ignored");

    // R2 bit 0 discarded
    wr_reg(8'h00, 32'hFFFF_FFFF);
    rd_chk(8'h00, 32'h0000_FFFE, "R2 group bit0 dropped");
    wr_reg(8'h00, 0);
    pulse(16'h0001);
    rd_chk(8'h04, 0, "R2 source 0 ignored");

    // R1 latch, R3 masked-off output
    pulse(16'h0020);
    rd_chk(8'h04, 32'h20, "R1 pending bit5");
    lvl_chk(0, "R3 masked source silent");

    // R12 registered output
    wr_reg(8'h40, 32'h20);
    push(1, 0, "R12 level not yet updated");
    lvl_chk(5, "R12 level after one more edge");

    // R4 groups
    pulse(16'h0200);
    wr_reg(8'h40, 32'h220);
    lvl_chk(9, "R4 low group highest index");
    wr_reg(8'h00, 32'h20);
    lvl_chk(5, "R4 high group beats higher index");
    wr_reg(8'h00, 0);

    // R8 acknowledge
    ack(4'd9);
    lvl_chk(5, "R8 ack drops source 9");
    rd_chk(8'h04, 32'h20, "R8 pending after ack");

    // R9 collisions
    @(negedge clk); src_pulse = 16'h0020; ack_valid = 1; ack_num = 4'd5;
    @(negedge clk); src_pulse = '0; ack_valid = 0;
    rd_chk(8'h04, 32'h20, "R9 request beats ack");
    @(negedge clk); src_pulse = 16'h0020; bus_addr = 8'h0C; bus_wdata = 32'h20; bus_wr = 1;
    @(negedge clk); src_pulse = '0; bus_wr = 0;
    rd_chk(8'h04, 32'h20, "R9 request beats clear");

    // R5 clear register
    wr_reg(8'h08, 32'h0400);
    rd_chk(8'h08, 32'h0400, "R6 alias readback");
    wr_reg(8'h0C, 32'hFFFF_FFFF);
    rd_chk(8'h04, 0, "R5 clear pending");
    rd_chk(8'h08, 0, "R5 clear force0");
    lvl_chk(0, "R5 level idle after clear");

    // R6 force set/clear halves and alias replace
    wr_reg(8'h8C, 32'h0000_00F0);
    wr_reg(8'h8C, 32'h0030_0002);
    rd_chk(8'h8C, 32'hC2, "R6 set and clear halves");
    wr_reg(8'h08, 32'hFFFF_0006);
    rd_chk(8'h80, 32'h06, "R6 alias replaces force0");
    wr_reg(8'h40, 32'h4);
    lvl_chk(2, "R6 force drives level");

    // R7 broadcast
    wr_reg(8'h14, 32'h81);
    rd_chk(8'h14, 32'h80, "R7 broadcast readback");
    pulse(16'h0080);
    rd_chk(8'h04, 0, "R7 pending untouched");
    rd_chk(8'h80, 32'h86, "R7 force0 set");
    rd_chk(8'hBC, 32'h80, "R7 force15 set");
    wr_reg(8'h40, 32'h80);
    lvl_chk(7, "R7 broadcast drives level");
    ack(4'd7);
    rd_chk(8'h80, 32'h06, "R8 ack clears force0");
    rd_chk(8'hBC, 32'h80, "R8 ack leaves force15");

    // R11 extended width
    wr_reg(8'hC4, 32'hFFFF_FFFF);
    rd_chk(8'hC4, 32'hF, "R11 extended low nibble");

    // R13 read data idle
    lvl_chk(0, "R13 level idle");
    push(0, 0, "R13 rdata zero without read");

    // R14 reset mid-run
    @(negedge clk); rst_n = 0;
    @(negedge clk); rst_n = 1;
    rd_chk(8'hBC, 0, "R14 force15 reset");
    rd_chk(8'h40, 0, "R14 mask0 reset");
    rd_chk(8'hC4, 0, "R14 extended reset");

    wait (exp_q.size() == 0);
    #2;
    done = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

endmodule